// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a 32-bit RISC core and decides, once per enabled clock, where the next instruction comes from. It looks at the instruction word now being executed. It chooses one of four addresses: the following instruction, a PC-relative target for the equal and not-equal compare branches, a region-local jump target, or an address held in a register. The compare operands and the register-indirect address come from the register file.

For the call form of the jump, the unit also asks, in the same cycle, for the return address to be written into the link register. The register file takes that request and the written value from the link outputs. Fetch memory, pipeline hazards, delay slots and exceptions belong to other blocks.

The reset input asserts asynchronously and is released through a short synchronizer. The PC therefore starts moving only a couple of clocks after reset is deasserted.

Top module: `pc_steer`

## Requirements
- R1: While reset is active, `pc` reads 0x00000000 and `link_we` is low.
- R2: An instruction that is not a branch or jump advances `pc` by 4. This includes opcode 000000 with a funct other than 001000.
- R3: Opcode 000100 (compare-equal branch) with `cmp_a == cmp_b` loads `pc + 4 + (sign-extended bits 15..0 << 2)`. When the operands differ, it loads `pc + 4`.
- R4: Opcode 000101 (compare-unequal branch) takes the same target when `cmp_a != cmp_b` and loads `pc + 4` when they are equal.
- R5: The branch offset is signed. Offset 0xFFFF returns to the branch itself, and larger negative offsets move backward.
- R6: Opcode 000010 loads bits 31..28 of `pc + 4` joined with bits 25..0 of the instruction and two zero bits. When `pc + 4` has crossed into the next 256 MB region, the upper bits come from that new region.
- R7: Opcode 000000 with funct (bits 5..0) 001000 loads `ind_addr` unchanged.
- R8: Opcode 000011 jumps like R6 and, in the same cycle, raises `link_we` with `link_val = pc + 4` and `link_idx = 31`.
- R9: While `adv_en` is low, `pc` holds its value and `link_we` stays low, whatever the instruction.
- R10: `link_we` is low for every instruction other than opcode 000011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Lets the PC move on this clock |
| instr | input | 32 | Instruction at the current PC |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| ind_addr | input | 32 | Register-indirect jump address |
| pc | output | 32 | Current program counter |
| link_val | output | 32 | Return address offered for the link write |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register number (31) |

## Verification
The call jump is the one case where two functions share a cycle. The link write must show the address of the following instruction while the PC loads the region-local target, and both must agree on the region bits. The bench sends the call both at an ordinary address and right after a register-indirect jump has left the PC at the last word of a 256 MB region. There, the target and the return address must both carry the new region bits. A call offered with `adv_en` low is also checked: it must neither write the link register nor move the PC. Every clock, the reference model checks the PC, the request, the link value and the link register number.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
  localparam int ILEN  = 32;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int OFF_W = 16;
  localparam int IDX_W = 26;
  localparam int REG_W = 5;

  localparam logic [OPC_W-1:0] OP_SPECIAL = 6'b000000;
  localparam logic [OPC_W-1:0] OP_JMP     = 6'b000010;
  localparam logic [OPC_W-1:0] OP_CALL    = 6'b000011;
  localparam logic [OPC_W-1:0] OP_BREQ    = 6'b000100;
  localparam logic [OPC_W-1:0] OP_BRNE    = 6'b000101;
  localparam logic [FN_W-1:0]  FN_JREG    = 6'b001000;
  localparam logic [REG_W-1:0] LINK_REG   = 5'd31;

  typedef enum logic [2:0] {
    FLOW_SEQ, FLOW_BEQ, FLOW_BNE, FLOW_JMP, FLOW_JAL, FLOW_JREG
  } flow_e;
endpackage

// File: rtl/pcu_rst_sync.sv
`timescale 1ns/1ps
module pcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/pcu_decode.sv
`timescale 1ns/1ps
module pcu_decode
  import pcu_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output flow_e           flow
);
  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;

  assign opc = instr[ILEN-1 -: OPC_W];
  assign fn  = instr[FN_W-1:0];

  always_comb begin
    flow = FLOW_SEQ;
    case (opc)
      OP_BREQ:    flow = FLOW_BEQ;
      OP_BRNE:    flow = FLOW_BNE;
      OP_JMP:     flow = FLOW_JMP;
      OP_CALL:    flow = FLOW_JAL;
      OP_SPECIAL: if (fn == FN_JREG) flow = FLOW_JREG;
      default:    flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/pcu_targets.sv
`timescale 1ns/1ps
module pcu_targets
  import pcu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [ILEN-1:0] instr,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_pc,
  output logic [XLEN-1:0] jmp_pc
);
  localparam int ALIGN    = 2;
  localparam int EXT_W    = XLEN - OFF_W - ALIGN;
  localparam int REGION_W = XLEN - IDX_W - ALIGN;

  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  disp;

  assign off = instr[OFF_W-1:0];
  assign idx = instr[IDX_W-1:0];

  always_comb begin
    seq_pc = pc + XLEN'(4);
    disp   = {{EXT_W{off[OFF_W-1]}}, off, {ALIGN{1'b0}}};
    br_pc  = seq_pc + disp;
    jmp_pc = {seq_pc[XLEN-1 -: REGION_W], idx, {ALIGN{1'b0}}};
  end
endmodule

// File: rtl/pcu_select.sv
`timescale 1ns/1ps
module pcu_select
  import pcu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e           flow,
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_pc,
  input  logic [XLEN-1:0] jmp_pc,
  input  logic [XLEN-1:0] ind_addr,
  output logic [XLEN-1:0] nxt_pc,
  output logic            link_req
);
  logic same;

  always_comb begin
    same     = (cmp_a == cmp_b);
    nxt_pc   = seq_pc;
    link_req = 1'b0;
    case (flow)
      FLOW_BEQ:  if (same)  nxt_pc = br_pc;
      FLOW_BNE:  if (!same) nxt_pc = br_pc;
      FLOW_JMP:  nxt_pc = jmp_pc;
      FLOW_JAL:  begin nxt_pc = jmp_pc; link_req = 1'b1; end
      FLOW_JREG: nxt_pc = ind_addr;
      default:   nxt_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/pc_steer.sv
`timescale 1ns/1ps
module pc_steer
  import pcu_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] RESET_PC    = '0,
  parameter int              SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_en,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  input  logic [XLEN-1:0] ind_addr,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] link_val,
  output logic            link_we,
  output logic [REG_W-1:0] link_idx
);
  localparam int REGION_W = XLEN - IDX_W - 2;

  logic            rst_q;
  flow_e           flow;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, nxt_pc;
  logic [XLEN-1:0] pc_q, pc_d;
  logic            link_req;

  pcu_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  pcu_decode u_dec (.instr(instr), .flow(flow));

  pcu_targets #(.XLEN(XLEN)) u_tgt (
    .pc(pc_q), .instr(instr), .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc)
  );

  pcu_select #(.XLEN(XLEN)) u_sel (
    .flow(flow), .cmp_a(cmp_a), .cmp_b(cmp_b), .seq_pc(seq_pc),
    .br_pc(br_pc), .jmp_pc(jmp_pc), .ind_addr(ind_addr),
    .nxt_pc(nxt_pc), .link_req(link_req)
  );

  always_comb begin
    pc_d = pc_q;
    if (adv_en) pc_d = nxt_pc;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc       = pc_q;
  assign link_val = seq_pc;
  assign link_we  = link_req & adv_en & rst_q;
  assign link_idx = LINK_REG;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !adv_en |=> $stable(pc));
  assert_nolink_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !adv_en |-> !link_we);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (adv_en && flow == FLOW_SEQ) |=> pc == $past(seq_pc));
  assert_fall_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (adv_en && flow == FLOW_BEQ && cmp_a != cmp_b) |=> pc == $past(pc) + XLEN'(4));
  assert_region_R8: assert property (@(posedge clk) disable iff (!rst_q)
    link_we |=> pc[XLEN-1 -: REGION_W] == $past(link_val[XLEN-1 -: REGION_W]));
  assert_linkval_R8: assert property (@(posedge clk) disable iff (!rst_q)
    link_we |-> link_val == pc + XLEN'(4));
endmodule

// File: tb/test_pc_steer.sv
`timescale 1ns/1ps
module test_pc_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_en = 1'b0;
  logic [31:0] instr = 32'h2000_0000;
  logic [31:0] cmp_a = '0, cmp_b = '0, ind_addr = '0;
  logic [31:0] pc, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] m_pc = '0;

  always #10 clk = ~clk;

  pc_steer i_pc_steer (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .instr(instr),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .ind_addr(ind_addr),
    .pc(pc), .link_val(link_val), .link_we(link_we), .link_idx(link_idx)
  );

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [15:0] off);
    return {op, 10'd0, off};
  endfunction
  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction
  function automatic logic [31:0] mk_r(input logic [5:0] fn);
    return {6'd0, 5'd9, 15'd0, fn};
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] ins,
                                           input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] r);
    logic [31:0] step = p + 32'd4;
    int signed   off  = int'($signed(ins[15:0])) * 4;
    case (ins[31:26])
      6'b000100: return (a == b) ? step + 32'(off) : step;
      6'b000101: return (a != b) ? step + 32'(off) : step;
      6'b000010, 6'b000011: return {step[31:28], ins[25:0], 2'b00};
      6'b000000: return (ins[5:0] == 6'b001000) ? r : step;
      default:   return step;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] r, input logic en, input string tag);
    logic want_link;
    instr = ins; cmp_a = a; cmp_b = b; ind_addr = r; adv_en = en;
    #5;
    want_link = en && (ins[31:26] == 6'b000011);
    check({tag, " pc"}, pc, m_pc);
    check({tag, " link_we R10"}, {31'd0, link_we}, {31'd0, want_link});
    if (want_link) begin
      check({tag, " link_val R8"}, link_val, m_pc + 32'd4);
      check({tag, " link_idx R8"}, {27'd0, link_idx}, 32'd31);
    end
    @(posedge clk);
    if (en) m_pc = ref_next(m_pc, ins, a, b, r);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(32'h2000_0000, 0, 0, 0, 1'b0, "idle");
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset pc", pc, 32'h0);
    check("R1 reset link_we", {31'd0, link_we}, 32'd0);
    rst_n = 1'b1;
    idle(3);
    step(32'h2008_0005, 0, 0, 0, 1'b1, "R2 addi");
    step(mk_r(6'b100000), 0, 0, 32'h0000_5550, 1'b1, "R2 add funct");
    step(mk_i(6'b000100, 16'd25), 7, 7, 0, 1'b1, "R3 beq taken");
    step(mk_i(6'b000100, 16'd25), 7, 8, 0, 1'b1, "R3 beq fall");
    step(mk_i(6'b000101, 16'd3), 1, 2, 0, 1'b1, "R4 bne taken");
    step(mk_i(6'b000101, 16'd3), 5, 5, 0, 1'b1, "R4 bne fall");
    step(mk_i(6'b000100, 16'hFFFF), 0, 0, 0, 1'b1, "R5 self loop");
    step(mk_i(6'b000101, 16'hFFF0), 1, 0, 0, 1'b1, "R5 backward");
    step(mk_r(6'b001000), 0, 0, 32'h0FFF_FFFC, 1'b1, "R7 jr");
    step(mk_j(6'b000010, 26'h10), 0, 0, 0, 1'b1, "R6 j region");
    step(mk_j(6'b000011, 26'h100), 0, 0, 0, 1'b1, "R8 jal");
    step(mk_j(6'b000011, 26'h200), 0, 0, 0, 1'b0, "R9 jal held");
    step(mk_i(6'b000100, 16'd9), 3, 3, 0, 1'b0, "R9 beq held");
    step(mk_r(6'b001000), 0, 0, 32'h1FFF_FFFC, 1'b1, "R7 jr edge");
    step(mk_j(6'b000011, 26'h3), 0, 0, 0, 1'b1, "R8 jal crossing");
    step(mk_r(6'b001000), 0, 0, 32'h0000_1233, 1'b1, "R7 jr raw");
    step(32'h2000_0000, 0, 0, 0, 1'b1, "R2 after");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins;
      logic [31:0] a = $urandom & 32'h3;
      logic [31:0] b = $urandom & 32'h3;
      case ($urandom % 7)
        0: ins = mk_i(6'b000100, 16'($urandom));
        1: ins = mk_i(6'b000101, 16'($urandom));
        2: ins = mk_j(6'b000010, 26'($urandom));
        3: ins = mk_j(6'b000011, 26'($urandom));
        4: ins = mk_r(6'b001000);
        5: ins = mk_r(6'($urandom));
        default: ins = $urandom;
      endcase
      step(ins, a, b, $urandom, ($urandom % 5) != 0, "mix R3 R4 R6 R8");
    end
    #3 rst_n = 1'b0;
    #2 m_pc = '0;
    check("R1 async reset pc", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    step(mk_i(6'b000100, 16'd1), 4, 4, 0, 1'b1, "R3 after reset");
    step(32'h2000_0000, 0, 0, 0, 1'b0, "R1 final");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule